// File: doc/BRIEF.md
# Sticky Event Status and Interrupt Pin Controller

This block gathers single-cycle event pulses from a number of register groups into sticky status bits. Each group has a status register and an enable register of the same width. Events latch whether or not their enable bit is set. The enable bits decide only whether a latched bit asserts the shared active-low interrupt pin. The pin is modelled as an output value and an output enable, so that a pad outside the block can float it.

Two configuration inputs are read at run time. `cfg_clr_on_read` picks how software clears latched bits. When it is 0, a write clears the bits written as 1. When it is 1, a read of the status register clears the whole register. Groups flagged in `grp_exempt` ignore this choice and always use write-to-clear. `cfg_idle_drive` picks whether the pin floats or drives high when no enabled bit is pending.

The pin comes from a three-state machine. In `PIN_FLOAT` the output enable is low. In `PIN_HIGH` the pin drives 1. In `PIN_LOW` the pin drives 0. On every clock edge the machine moves to `PIN_LOW` if any enabled bit is pending. Otherwise it moves to `PIN_HIGH` if `cfg_idle_drive` is 1, or to `PIN_FLOAT` if it is 0. Every state can reach every other state in one edge. The CPU address is `{group, sel}`. The low bit `sel` is 0 for the status register and 1 for the enable register.

Top module: `irqc_top`

## Requirements
- R1: A 1 on an event input sets the matching status bit at the next clock edge. The bit then stays set until a clear selected by R2, R3 or R4, whatever its enable bit holds.
- R2: With `cfg_clr_on_read`=0, a write to a status register (address bit 0 = 0) clears each bit written as 1. Bits written as 0 keep their value.
- R3: With `cfg_clr_on_read`=1, a read of a non-exempt group's status register clears all of its bits. Writes to that status register have no effect.
- R4: A group whose `grp_exempt` bit is 1 always uses the write-to-clear rule of R2, and reading it does not clear it.
- R5: An event that arrives in the same cycle as a clear of that bit wins, so the bit stays set.
- R6: A read loads `cpu_rdata` at the clock edge that samples `cpu_rd`. The data comes from the register selected by address bit 0 (0 = status, 1 = enable) in the group given by the upper address bits. It is the value held before any clear caused by that read.
- R7: One edge after any status bit is set together with its enable bit, the pin drives low (`irq_oe`=1, `irq_o`=0).
- R8: One edge after no enabled status bit is set, the pin floats (`irq_oe`=0) if `cfg_idle_drive`=0, or drives high (`irq_oe`=1, `irq_o`=1) if `cfg_idle_drive`=1.
- R9: A write to an enable register (address bit 0 = 1) stores the data. Enable bits gate only the pin and never the latching of status.
- R10: After reset all status bits, enable bits and `cpu_rdata` are 0, and the pin floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clr_on_read | input | 1 | 1 = status is cleared by a read, 0 = cleared by a write of ones |
| cfg_idle_drive | input | 1 | 1 = drive the pin high when idle, 0 = float it |
| grp_exempt | input | NUM_GROUPS | Per-group flag forcing write-to-clear |
| evt_i | input | NUM_GROUPS*GRP_W | Event pulses, group g at bits [g*GRP_W +: GRP_W] |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | GSEL_W+1 | {group, sel}; sel 0 = status, 1 = enable |
| cpu_wdata | input | GRP_W | Write data |
| cpu_rdata | output | GRP_W | Registered read data |
| irq_o | output | 1 | Interrupt pin value (active low) |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The hardest case to reach is a clear and an event landing on the same bit in the same cycle. The same applies to a read-to-clear on a group that another input marks as exempt. Directed steps drive an event pulse on the very cycle of a clearing write, and on the very cycle of a clearing read. A long random run then flips the clear mode, the idle drive and the exempt mask every few hundred cycles under dense events. This mixes all the clear paths with the pin transitions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        PIN_FLOAT = 2'd0,
        PIN_HIGH  = 2'd1,
        PIN_LOW   = 2'd2
    } pin_state_e;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/irqc_group.sv
module irqc_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         wr_stat,
    input  logic         rd_stat,
    input  logic         wr_en,
    input  logic         clr_on_read,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic         pending
);

    logic [W-1:0] status_nx;

    always_comb begin
        status_nx = status;
        if (wr_stat && !clr_on_read) begin
            status_nx = status_nx & ~wdata;
        end
        if (rd_stat && clr_on_read) begin
            status_nx = '0;
        end
        status_nx = status_nx | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= status_nx;
            if (wr_en) begin
                enable <= wdata;
            end
        end
    end

    assign pending = |(status & enable);

endmodule

// File: rtl/irqc_pin_fsm.sv
module irqc_pin_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic idle_drive,
    output logic irq_o,
    output logic irq_oe
);

    pin_state_e state, state_nx;

    always_comb begin
        unique case (state)
            PIN_FLOAT,
            PIN_HIGH,
            PIN_LOW: begin
                if (pending) begin
                    state_nx = PIN_LOW;
                end else if (idle_drive) begin
                    state_nx = PIN_HIGH;
                end else begin
                    state_nx = PIN_FLOAT;
                end
            end
            default: state_nx = PIN_FLOAT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PIN_FLOAT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            PIN_LOW: begin
                irq_o  = 1'b0;
                irq_oe = 1'b1;
            end
            PIN_HIGH: begin
                irq_o  = 1'b1;
                irq_oe = 1'b1;
            end
            default: begin
                irq_o  = 1'b1;
                irq_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_W      = 8,
    localparam int GSEL_W    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int AW        = GSEL_W + 1,
    localparam int EW        = NUM_GROUPS * GRP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_clr_on_read,
    input  logic                  cfg_idle_drive,
    input  logic [NUM_GROUPS-1:0] grp_exempt,
    input  logic [EW-1:0]         evt_i,
    input  logic                  cpu_wr,
    input  logic                  cpu_rd,
    input  logic [AW-1:0]         cpu_addr,
    input  logic [GRP_W-1:0]      cpu_wdata,
    output logic [GRP_W-1:0]      cpu_rdata,
    output logic                  irq_o,
    output logic                  irq_oe
);

    logic [GSEL_W-1:0]     grp_idx;
    reg_sel_e              reg_sel;
    logic [EW-1:0]         status_flat;
    logic [EW-1:0]         enable_flat;
    logic [NUM_GROUPS-1:0] pend_vec;
    logic [GRP_W-1:0]      rd_mux;

    assign grp_idx = cpu_addr[AW-1:1];
    assign reg_sel = reg_sel_e'(cpu_addr[0]);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit;
        assign hit = (grp_idx == GSEL_W'(g));

        irqc_group #(.W(GRP_W)) u_group (
            .clk         (clk),
            .rst_n       (rst_n),
            .evt         (evt_i[g*GRP_W +: GRP_W]),
            .wr_stat     (cpu_wr && hit && (reg_sel == SEL_STATUS)),
            .rd_stat     (cpu_rd && hit && (reg_sel == SEL_STATUS)),
            .wr_en       (cpu_wr && hit && (reg_sel == SEL_ENABLE)),
            .clr_on_read (cfg_clr_on_read && !grp_exempt[g]),
            .wdata       (cpu_wdata),
            .status      (status_flat[g*GRP_W +: GRP_W]),
            .enable      (enable_flat[g*GRP_W +: GRP_W]),
            .pending     (pend_vec[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_idx == GSEL_W'(g)) begin
                rd_mux = (reg_sel == SEL_ENABLE) ? enable_flat[g*GRP_W +: GRP_W]
                                                 : status_flat[g*GRP_W +: GRP_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (cpu_rd) begin
            cpu_rdata <= rd_mux;
        end
    end

    irqc_pin_fsm u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (|pend_vec),
        .idle_drive (cfg_idle_drive),
        .irq_o      (irq_o),
        .irq_oe     (irq_oe)
    );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int EW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_idle_drive,
    input logic          cpu_wr,
    input logic          cpu_rd,
    input logic [EW-1:0] evt_i,
    input logic [EW-1:0] status_flat,
    input logic [EW-1:0] enable_flat,
    input logic          irq_o,
    input logic          irq_oe
);

    logic pend;
    assign pend = |(status_flat & enable_flat);

    a_r7_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> (irq_oe && !irq_o));

    a_r8_pin_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !cfg_idle_drive) |=> !irq_oe);

    a_r8_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && cfg_idle_drive) |=> (irq_oe && irq_o));

    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr && !cpu_rd) |=> ((status_flat & $past(status_flat)) == $past(status_flat)));

    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((status_flat & $past(evt_i)) == $past(evt_i)));

endmodule

bind irqc_top irqc_checker #(.EW(NUM_GROUPS * GRP_W)) u_irqc_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_idle_drive (cfg_idle_drive),
    .cpu_wr         (cpu_wr),
    .cpu_rd         (cpu_rd),
    .evt_i          (evt_i),
    .status_flat    (status_flat),
    .enable_flat    (enable_flat),
    .irq_o          (irq_o),
    .irq_oe         (irq_oe)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;

    localparam int NG = 4;
    localparam int W  = 8;
    localparam int AW = 3;
    localparam int EW = NG * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_clr_on_read = 1'b0;
    logic          cfg_idle_drive = 1'b0;
    logic [NG-1:0] grp_exempt = '0;
    logic [EW-1:0] evt_i = '0;
    logic          cpu_wr = 1'b0;
    logic          cpu_rd = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [W-1:0]  cpu_wdata = '0;
    logic [W-1:0]  cpu_rdata;
    logic          irq_o;
    logic          irq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    irqc_top #(.NUM_GROUPS(NG), .GRP_W(W)) u_irqc_top (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_clr_on_read (cfg_clr_on_read),
        .cfg_idle_drive  (cfg_idle_drive),
        .grp_exempt      (grp_exempt),
        .evt_i           (evt_i),
        .cpu_wr          (cpu_wr),
        .cpu_rd          (cpu_rd),
        .cpu_addr        (cpu_addr),
        .cpu_wdata       (cpu_wdata),
        .cpu_rdata       (cpu_rdata),
        .irq_o           (irq_o),
        .irq_oe          (irq_oe)
    );

    always #5 clk = ~clk;

    // reference model, built from the requirements
    logic [W-1:0] m_stat [NG];
    logic [W-1:0] m_en   [NG];
    logic [W-1:0] m_rdata;
    logic         m_oe, m_o;

    function automatic logic any_pend();
        logic p = 1'b0;
        for (int g = 0; g < NG; g++) p |= |(m_stat[g] & m_en[g]);
        return p;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                m_stat[g] = '0;
                m_en[g]   = '0;
            end
            m_rdata = '0;
            m_oe = 1'b0;
            m_o  = 1'b1;
        end else begin
            int ga;
            logic sel;
            ga  = int'(cpu_addr >> 1);
            sel = cpu_addr[0];
            if (any_pend()) begin
                m_oe = 1'b1; m_o = 1'b0;
            end else if (cfg_idle_drive) begin
                m_oe = 1'b1; m_o = 1'b1;
            end else begin
                m_oe = 1'b0; m_o = 1'b1;
            end
            if (cpu_rd) m_rdata = sel ? m_en[ga] : m_stat[ga];
            for (int g = 0; g < NG; g++) begin
                logic cor;
                logic [W-1:0] nx;
                cor = cfg_clr_on_read && !grp_exempt[g];
                nx  = m_stat[g];
                if (cpu_wr && ga == g && !sel && !cor) nx &= ~cpu_wdata;
                if (cpu_rd && ga == g && !sel && cor)  nx = '0;
                nx |= evt_i[g*W +: W];
                m_stat[g] = nx;
                if (cpu_wr && ga == g && sel) m_en[g] = cpu_wdata;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (cpu_rdata !== m_rdata) begin
                fails++;
                $display("FAIL R6 rdata actual %h expected %h", cpu_rdata, m_rdata);
            end
            checks++;
            if (irq_oe !== m_oe || (m_oe && irq_o !== m_o)) begin
                fails++;
                $display("FAIL R7/R8 pin actual oe=%b o=%b expected oe=%b o=%b",
                         irq_oe, irq_o, m_oe, m_o);
            end
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input logic wr, input logic rd, input logic [AW-1:0] a,
                      input logic [W-1:0] d, input logic [EW-1:0] e);
        @(negedge clk);
        cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = d; evt_i = e;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0; evt_i = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [W-1:0] exp);
        op(1'b0, 1'b1, a, '0, '0);
        chk(tag, cpu_rdata, exp);
    endtask

    task automatic pin_chk(input string tag, input logic oe, input logic o);
        @(negedge clk);
        chk(tag, {6'd0, irq_oe, irq_oe & irq_o}, {6'd0, oe, oe & o});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 rdata", cpu_rdata, 8'h00);
        chk("R10 pin oe", {7'd0, irq_oe}, 8'h00);
        rd_chk("R10 status", 3'd2, 8'h00);

        // R1 / R9: latch with enable clear, pin stays floating
        op(1'b0, 1'b0, 3'd0, '0, 32'h0000_0800);
        rd_chk("R1 latch", 3'd2, 8'h08);
        pin_chk("R9 masked", 1'b0, 1'b1);

        // R8 idle drive high
        cfg_idle_drive = 1'b1;
        @(negedge clk);
        pin_chk("R8 idle high", 1'b1, 1'b1);

        // R7 / R9 enabled bit drives pin low
        op(1'b1, 1'b0, 3'd3, 8'h08, '0);
        pin_chk("R7 pin low", 1'b1, 1'b0);
        rd_chk("R9 enable readback", 3'd3, 8'h08);

        // R2 write-to-clear
        op(1'b1, 1'b0, 3'd2, 8'hF7, '0);
        rd_chk("R2 zero bits keep", 3'd2, 8'h08);
        op(1'b1, 1'b0, 3'd2, 8'h08, '0);
        rd_chk("R2 one bits clear", 3'd2, 8'h00);
        pin_chk("R8 back high", 1'b1, 1'b1);

        // R3 / R6 read-to-clear
        cfg_clr_on_read = 1'b1;
        op(1'b0, 1'b0, 3'd0, '0, 32'h0005_0000);
        op(1'b1, 1'b0, 3'd4, 8'hFF, '0);
        rd_chk("R6 pre-clear value", 3'd4, 8'h05);
        rd_chk("R3 read cleared", 3'd4, 8'h00);

        // R4 exempt group
        grp_exempt = 4'b1000;
        op(1'b0, 1'b0, 3'd0, '0, 32'h0200_0000);
        rd_chk("R4 read keeps", 3'd6, 8'h02);
        rd_chk("R4 read keeps again", 3'd6, 8'h02);
        op(1'b1, 1'b0, 3'd6, 8'h02, '0);
        rd_chk("R4 write clears", 3'd6, 8'h00);

        // R5 event beats clear, both clear modes
        op(1'b0, 1'b1, 3'd0, '0, 32'h0000_0001);
        rd_chk("R5 read clear loses", 3'd0, 8'h01);
        rd_chk("R3 then cleared", 3'd0, 8'h00);
        cfg_clr_on_read = 1'b0;
        op(1'b0, 1'b0, 3'd0, '0, 32'h0000_0001);
        op(1'b1, 1'b0, 3'd0, 8'h01, 32'h0000_0001);
        rd_chk("R5 write clear loses", 3'd0, 8'h01);

        // random phase, checked by the model each cycle
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (i % 250 == 0) begin
                cfg_clr_on_read = 1'($urandom);
                cfg_idle_drive  = 1'($urandom);
                grp_exempt      = NG'($urandom);
            end
            evt_i     = $urandom & $urandom & $urandom;
            cpu_addr  = AW'($urandom);
            cpu_wdata = W'($urandom);
            begin
                int r;
                r = int'($urandom % 8);
                cpu_rd = (r < 3);
                cpu_wr = (r >= 3 && r < 5);
            end
        end
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0; evt_i = '0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule